// File: doc/BRIEF.md
# Oscillator Trim Register Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (SCL clock line, SDA open-drain data line). It runs on a fast system clock and oversamples both bus lines. It holds three small configuration registers for a trimmed oscillator: an output divider select, a control nibble and a signed frequency offset. It also returns a 10-bit die-temperature code that a separate sensor supplies. Every access begins with the 7-bit device address and a direction bit. A write then carries a command byte that selects a register, followed by data. A read returns the register that the most recently accepted command selected.

The block drives the bus only through a pull-down enable, which the surrounding pad logic turns into an open-drain output. The two-byte temperature read is the only access that returns a different byte on each data slot. Its second byte comes from a copy taken when the first byte is loaded, so a sensor update between the two bytes cannot mix two readings. The master may stop after the first temperature byte by answering it with a not-acknowledge. SCL and SDA are sampled through two-flop synchronizers. For a correct bit decode, both SCL half-periods must be several system clocks long. This holds for 100 kHz and 400 kHz buses against a clock in the tens of MHz.

Top module: `osc_trim_twi_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 100010 followed by `addr_lsb_i`, in both directions (bit 0: 0 = write, 1 = read). It does not acknowledge any other address byte, and it ignores the rest of that transfer until the next START or STOP.
- R2: In a write, command byte 5Dh, 60h or 66h is acknowledged and becomes the pointer. The next data byte is acknowledged and stored: 5Dh goes to `fsel_o`, 66h goes to `tune_o`, and for 60h only data bits 3:0 are kept in `ctl_o[3:0]`, with `ctl_o[7:4]` reading 0. Each data byte changes at most one register, and only while SCL is low.
- R3: The pointer never advances. Further data bytes in one write overwrite the same register. Further bytes of a read repeat the same register. A read sent without a command uses the pointer from the last accepted command (5Dh after reset).
- R4: A read with pointer 64h returns `temp_code_i[9:2]` as the first byte and {`temp_code_i[1:0]`, 000000} as the second byte, each sent MSB first. Any byte after the second reads 00h.
- R5: The second temperature byte comes from the code sampled when the first byte was loaded, even if `temp_code_i` has changed since then.
- R6: A not-acknowledge from the master after a read byte ends transmission. SDA then stays released until the next START.
- R7: An unknown command byte is not acknowledged. The pointer and all registers stay unchanged, and the data bytes that follow are not acknowledged. A data byte written after command 64h is not acknowledged and changes nothing.
- R8: While `rst_n` is low at a clock edge, all registers clear to 0 and the SDA pull-down is released.
- R9: A START at any point, including in the middle of a byte, abandons the partial byte and begins a new address phase. A STOP in the middle of a transfer returns the block to idle without a write.
- R10: The SDA pull-down only becomes asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired level, including this block's own pull-down) |
| addr_lsb_i | input | 1 | Strap that sets bit 0 of the 7-bit device address |
| temp_code_i | input | TEMP_W (10) | Two's-complement temperature in quarter degrees from the sensor |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |
| fsel_o | output | 8 | Divider select register (command 5Dh) |
| ctl_o | output | 8 | Control register (command 60h), upper nibble reads 0 |
| tune_o | output | 8 | Signed frequency offset register (command 66h) |

## Verification
The hardest case to reach from the ports is a sensor update that lands between the two bytes of one temperature read. The bench reaches it by acknowledging the first byte and then changing `temp_code_i` while SCL is held low, before it clocks the second byte. It then clocks a third byte to see the zero fill. The bench also sends a START in the middle of a byte and a STOP in the middle of a byte, then checks that the next clean transfer still decodes correctly. It sweeps the full 7-bit address space under both strap levels.

// File: rtl/osc_twi_pkg.sv
`timescale 1ns/1ps
// Package: shared command codes, device address, state types and command
// classification for the oscillator trim bus slave.
package osc_twi_pkg;

    localparam logic [7:0] CMD_FSEL = 8'h5D;
    localparam logic [7:0] CMD_CTL  = 8'h60;
    localparam logic [7:0] CMD_TEMP = 8'h64;
    localparam logic [7:0] CMD_TUNE = 8'h66;

    localparam logic [5:0] DEV_ADDR_HI = 6'b100010;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_RX_ACK,
        LS_TX,
        LS_TX_ACK,
        LS_WAIT
    } link_state_t;

    typedef enum logic [1:0] {
        RB_ADDR,
        RB_CMD,
        RB_DATA
    } rx_role_t;

    // True for every command byte the slave answers
    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_FSEL) || (c == CMD_CTL) || (c == CMD_TEMP) || (c == CMD_TUNE);
    endfunction

    // True for commands that accept a data byte in a write
    function automatic logic cmd_writable(input logic [7:0] c);
        return (c == CMD_FSEL) || (c == CMD_CTL) || (c == CMD_TUNE);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
// Synchronizer for one bus line: a STAGES-deep flop chain into the system
// clock, with single-cycle rise and fall strobes.
// Assumes STAGES >= 2 and that the line is idle-high (reset value 1).
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw line through the chain and keep the previous synced level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = level_o & ~last_q;
    assign fall_o  = ~level_o & last_q;

endmodule

// File: rtl/twi_reg_bank.sv
`timescale 1ns/1ps
// Register bank: divider select, control nibble and offset registers, plus
// the temperature byte path with a low-byte holding copy.
// Assumes a write strobe lasts one cycle and that cap_en pulses in the cycle
// where the first read byte is loaded, so byte 0 and the hold share a sample.
module twi_reg_bank
    import osc_twi_pkg::*;
#(
    parameter int TEMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        ptr,
    input  logic [1:0]        rd_idx,
    input  logic              cap_en,
    input  logic [TEMP_W-1:0] temp_code_i,
    output logic [7:0]        tx_byte,
    output logic [7:0]        fsel_o,
    output logic [7:0]        ctl_o,
    output logic [7:0]        tune_o
);

    localparam int PAD_W = 16 - TEMP_W;

    logic [15:0] temp_word;
    logic [7:0]  fsel_q, tune_q, hold_lo_q;
    logic [3:0]  ctl_q;

    // Left-justify the temperature code into a 16-bit word
    generate
        if (PAD_W > 0) begin : g_pad
            assign temp_word = {temp_code_i, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign temp_word = temp_code_i[15:0];
        end
    endgenerate

    // Store a write into the register the pointer selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel_q <= '0;
            ctl_q  <= '0;
            tune_q <= '0;
        end else if (wr_en) begin
            case (ptr)
                CMD_FSEL: fsel_q <= wr_data;
                CMD_CTL:  ctl_q  <= wr_data[3:0];
                CMD_TUNE: tune_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Capture the low temperature byte when the high byte is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo_q <= '0;
        end else if (cap_en && (ptr == CMD_TEMP)) begin
            hold_lo_q <= temp_word[7:0];
        end
    end

    // Select the byte to transmit from pointer and byte slot
    always_comb begin
        case (ptr)
            CMD_FSEL: tx_byte = fsel_q;
            CMD_CTL:  tx_byte = {4'b0000, ctl_q};
            CMD_TUNE: tx_byte = tune_q;
            CMD_TEMP: begin
                if (rd_idx == 2'd0)      tx_byte = temp_word[15:8];
                else if (rd_idx == 2'd1) tx_byte = hold_lo_q;
                else                     tx_byte = 8'h00;
            end
            default:  tx_byte = 8'h00;
        endcase
    end

    assign fsel_o = fsel_q;
    assign ctl_o  = {4'b0000, ctl_q};
    assign tune_o = tune_q;

endmodule

// File: rtl/twi_link_fsm.sv
`timescale 1ns/1ps
// Bus protocol engine: START/STOP detection, byte shifting, address match,
// command decode, acknowledge generation and byte transmission.
// Assumes synchronized line levels and edge strobes, and an SCL low time of
// several system clocks so that the SDA pull-down settles before SCL rises.
module twi_link_fsm
    import osc_twi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_hi,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_hi,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic       addr_lsb_i,
    input  logic [7:0] tx_byte,
    output logic       sda_pull,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic [7:0] ptr,
    output logic [1:0] rd_idx,
    output logic       first_load
);

    link_state_t state_q;
    rx_role_t    role_q;
    logic        rw_q, mack_q, pull_q, wr_q;
    logic [3:0]  cnt_q;
    logic [7:0]  shreg_q, ptr_q;
    logic [1:0]  idx_q;
    logic        start_evt, stop_evt, ack_end;

    // Bus conditions: SDA moving while SCL stays high
    assign start_evt = scl_hi & sda_fall;
    assign stop_evt  = scl_hi & sda_rise;

    // End of the slave's acknowledge clock, and the first-byte load it causes
    assign ack_end    = (state_q == LS_RX_ACK) && scl_fall && !start_evt && !stop_evt;
    assign first_load = ack_end && (role_q == RB_ADDR) && rw_q;

    // Protocol state, shift register, pointer and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            role_q  <= RB_ADDR;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            pull_q  <= 1'b0;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            ptr_q   <= CMD_FSEL;
            idx_q   <= '0;
        end else begin
            wr_q <= 1'b0;
            if (start_evt) begin
                state_q <= LS_RX;
                role_q  <= RB_ADDR;
                cnt_q   <= '0;
                pull_q  <= 1'b0;
            end else if (stop_evt) begin
                state_q <= LS_IDLE;
                pull_q  <= 1'b0;
            end else begin
                case (state_q)
                    LS_RX: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[6:0], sda_hi};
                            cnt_q   <= cnt_q + 4'd1;
                        end else if (scl_fall && (cnt_q == 4'd8)) begin
                            case (role_q)
                                RB_ADDR: begin
                                    if (shreg_q[7:1] == {DEV_ADDR_HI, addr_lsb_i}) begin
                                        rw_q    <= shreg_q[0];
                                        idx_q   <= '0;
                                        pull_q  <= 1'b1;
                                        state_q <= LS_RX_ACK;
                                    end else begin
                                        state_q <= LS_WAIT;
                                    end
                                end
                                RB_CMD: begin
                                    if (cmd_known(shreg_q)) begin
                                        ptr_q   <= shreg_q;
                                        pull_q  <= 1'b1;
                                        state_q <= LS_RX_ACK;
                                    end else begin
                                        state_q <= LS_WAIT;
                                    end
                                end
                                default: begin
                                    if (cmd_writable(ptr_q)) begin
                                        wr_q    <= 1'b1;
                                        pull_q  <= 1'b1;
                                        state_q <= LS_RX_ACK;
                                    end else begin
                                        state_q <= LS_WAIT;
                                    end
                                end
                            endcase
                        end
                    end
                    LS_RX_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if ((role_q == RB_ADDR) && rw_q) begin
                                state_q <= LS_TX;
                                shreg_q <= tx_byte;
                                pull_q  <= ~tx_byte[7];
                            end else begin
                                state_q <= LS_RX;
                                pull_q  <= 1'b0;
                                role_q  <= (role_q == RB_ADDR) ? RB_CMD : RB_DATA;
                            end
                        end
                    end
                    LS_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                state_q <= LS_TX_ACK;
                                pull_q  <= 1'b0;
                            end else begin
                                shreg_q <= {shreg_q[6:0], 1'b0};
                                pull_q  <= ~shreg_q[6];
                                cnt_q   <= cnt_q + 4'd1;
                            end
                        end
                    end
                    LS_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_hi;
                            if (idx_q != 2'd2) idx_q <= idx_q + 2'd1;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                state_q <= LS_TX;
                                cnt_q   <= '0;
                                shreg_q <= tx_byte;
                                pull_q  <= ~tx_byte[7];
                            end else begin
                                state_q <= LS_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = pull_q;
    assign wr_en    = wr_q;
    assign wr_data  = shreg_q;
    assign ptr      = ptr_q;
    assign rd_idx   = idx_q;

endmodule

// File: rtl/osc_trim_twi_slave.sv
`timescale 1ns/1ps
// Top: two-wire bus slave serving the oscillator trim registers and the
// temperature code. Both bus lines pass through synchronizers; SDA is driven
// only through an open-drain pull-down enable.
// Assumes sda_i carries the wired bus level, including this block's own pull.
module osc_trim_twi_slave #(
    parameter int TEMP_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_lsb_i,
    input  logic [TEMP_W-1:0] temp_code_i,
    output logic              sda_pull_o,
    output logic [7:0]        fsel_o,
    output logic [7:0]        ctl_o,
    output logic [7:0]        tune_o
);

    localparam int N_LINES = 2;
    localparam int SCL_IX  = 1;
    localparam int SDA_IX  = 0;

    logic [N_LINES-1:0] raw_lines, lvl, rs, fl;
    logic [7:0]         tx_byte, wr_data, ptr;
    logic [1:0]         rd_idx;
    logic               wr_en, first_load;

    assign raw_lines = {scl_i, sda_i};

    // One synchronizer per bus line
    for (genvar li = 0; li < N_LINES; li++) begin : g_line
        twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[li]),
            .level_o (lvl[li]),
            .rise_o  (rs[li]),
            .fall_o  (fl[li])
        );
    end

    twi_link_fsm u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_hi     (lvl[SCL_IX]),
        .scl_rise   (rs[SCL_IX]),
        .scl_fall   (fl[SCL_IX]),
        .sda_hi     (lvl[SDA_IX]),
        .sda_rise   (rs[SDA_IX]),
        .sda_fall   (fl[SDA_IX]),
        .addr_lsb_i (addr_lsb_i),
        .tx_byte    (tx_byte),
        .sda_pull   (sda_pull_o),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ptr        (ptr),
        .rd_idx     (rd_idx),
        .first_load (first_load)
    );

    twi_reg_bank #(.TEMP_W(TEMP_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ptr         (ptr),
        .rd_idx      (rd_idx),
        .cap_en      (first_load),
        .temp_code_i (temp_code_i),
        .tx_byte     (tx_byte),
        .fsel_o      (fsel_o),
        .ctl_o       (ctl_o),
        .tune_o      (tune_o)
    );

endmodule

// File: rtl/osc_trim_twi_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties on the trim slave's ports, attached by bind.
module osc_trim_twi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic [7:0] fsel_o,
    input logic [7:0] ctl_o,
    input logic [7:0] tune_o
);

    logic after_rst = 1'b0;

    // Outputs are cleared in the cycle after a reset edge
    always_ff @(posedge clk) begin
        if (after_rst) begin
            // R8
            rst_state_chk: assert (fsel_o == 8'h00 && ctl_o == 8'h00 && tune_o == 8'h00 && !sda_pull_o)
                else $error("reset state not cleared");
        end
        after_rst <= !rst_n;
    end

    // R10
    pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i)
        else $error("SDA pull asserted while SCL high");

    // R2
    one_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fsel_o != $past(fsel_o), ctl_o != $past(ctl_o), tune_o != $past(tune_o)}))
        else $error("more than one register changed at once");

    // R2
    fsel_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_o != $past(fsel_o)) |-> !scl_i)
        else $error("divider select changed while SCL high");

    // R2
    tune_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_o != $past(tune_o)) |-> !scl_i)
        else $error("offset changed while SCL high");

    // R2
    ctl_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o != $past(ctl_o)) |-> !scl_i)
        else $error("control changed while SCL high");

endmodule

bind osc_trim_twi_slave osc_trim_twi_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .fsel_o     (fsel_o),
    .ctl_o      (ctl_o),
    .tune_o     (tune_o)
);

// File: tb/osc_trim_twi_slave_tb_top.sv
`timescale 1ns/1ps
module osc_trim_twi_slave_tb_top;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       strap = 1'b0;
    logic [9:0] temp = '0;
    logic       sda_line, sda_pull;
    logic [7:0] fsel, ctl, tune;

    int n_run = 0;
    int n_fail = 0;
    int viol = 0;
    logic prev_pull = 1'b0;

    assign sda_line = ~(m_low | sda_pull);

    always #2.5 clk = ~clk;

    osc_trim_twi_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .addr_lsb_i  (strap),
        .temp_code_i (temp),
        .sda_pull_o  (sda_pull),
        .fsel_o      (fsel),
        .ctl_o       (ctl),
        .tune_o      (tune)
    );

    // R10 monitor: pull-down must not rise while the master holds SCL high
    always @(posedge clk) begin
        if (rst_n && sda_pull && !prev_pull && m_scl) viol++;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_low = 1'b1; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_low = 1'b0; wt(H);
    endtask

    task automatic put_bit(input bit b);
        m_low = !b; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        m_low = 1'b0; wt(H);
        m_scl = 1'b1; wt(H / 2);
        b = sda_line; wt(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = !x;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit give_ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            v[i] = x;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [7:0] abyte(input bit rd);
        return {6'b100010, strap, rd};
    endfunction

    task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(cmd, a1);
        write_byte(d, a2);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] v);
        bit a;
        bus_start();
        write_byte(abyte(0), a);
        write_byte(cmd, a);
        bus_start();
        write_byte(abyte(1), a);
        read_byte(v, 0);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit a0, a1, a2, x;
        logic [7:0] v, v2, v3;
        logic [7:0] dlist [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        logic [7:0] clist [3] = '{8'h5D, 8'h66, 8'h60};
        int corners [6] = '{10'h3FE, 340, 300, 10'h200, 10'h1FF, 2};

        wt(8);
        rst_n = 1'b1;
        wt(2);
        // R8: reset state
        chk(fsel == 0 && ctl == 0 && tune == 0, "R8 regs", {fsel, ctl, tune}, 0);
        chk(!sda_pull, "R8 pull", sda_pull, 0);

        // R1: full address sweep, both strap levels
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                write_byte({ad[6:0], 1'b0}, a0);
                bus_stop();
                chk(a0 == (ad == {6'b100010, s[0]}), "R1 addr ack", a0, ad == {6'b100010, s[0]});
            end
        end
        strap = 1'b1;
        // R1: foreign address write has no effect
        bus_start();
        write_byte(8'h10, a0);
        write_byte(8'h5D, a1);
        write_byte(8'hAA, a2);
        bus_stop();
        chk(!a0 && fsel == 0, "R1 foreign write", fsel, 0);
        // R1: read direction acknowledged
        bus_start();
        write_byte(abyte(1), a0);
        read_byte(v, 0);
        bus_stop();
        chk(a0, "R1 read ack", a0, 1);

        // R2: write sweep and read-back
        for (int c = 0; c < 3; c++) begin
            for (int d = 0; d < 6; d++) begin
                wr_reg(clist[c], dlist[d], a0, a1, a2);
                chk(a0 && a1 && a2, "R2 acks", {a0, a1, a2}, 3'b111);
                v2 = (c == 0) ? fsel : (c == 1) ? tune : ctl;
                v3 = (c == 2) ? (dlist[d] & 8'h0F) : dlist[d];
                chk(v2 == v3, "R2 reg value", v2, v3);
                rd_reg(clist[c], v);
                chk(v == v3, "R2 read back", v, v3);
            end
        end

        // R3: multi-byte write overwrites the same register
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h66, a1);
        write_byte(8'h11, a2);
        write_byte(8'h22, a2);
        bus_stop();
        chk(tune == 8'h22 && fsel == 8'h80, "R3 no write increment", tune, 8'h22);
        // R3: multi-byte read repeats, read without command uses pointer
        bus_start();
        write_byte(abyte(1), a0);
        read_byte(v, 1);
        read_byte(v2, 1);
        read_byte(v3, 0);
        bus_stop();
        chk(v == 8'h22 && v2 == 8'h22 && v3 == 8'h22, "R3 read repeat", {v, v2, v3}, 24'h222222);

        // R4: temperature format over a sweep and corners
        for (int k = 0; k < 1030; k += 31) begin
            int code;
            code = (k < 1024) ? k : corners[(k - 1023) % 6];
            temp = code[9:0];
            bus_start();
            write_byte(abyte(0), a0);
            write_byte(8'h64, a1);
            bus_start();
            write_byte(abyte(1), a2);
            read_byte(v, 1);
            read_byte(v2, 0);
            bus_stop();
            chk(v == ((code >> 2) & 8'hFF), "R4 temp msb", v, (code >> 2) & 8'hFF);
            chk(v2 == ((code & 3) << 6), "R4 temp lsb", v2, (code & 3) << 6);
        end
        for (int j = 0; j < 6; j++) begin
            temp = corners[j][9:0];
            rd_reg(8'h64, v);
            chk(v == ((corners[j] >> 2) & 8'hFF), "R4 corner msb", v, (corners[j] >> 2) & 8'hFF);
        end

        // R5: sensor update between the two bytes; R4: third byte zero
        temp = 10'h3FF;
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h64, a1);
        bus_start();
        write_byte(abyte(1), a2);
        read_byte(v, 1);
        temp = 10'h000;
        wt(4 * H);
        read_byte(v2, 1);
        read_byte(v3, 0);
        bus_stop();
        chk(v == 8'hFF, "R5 msb", v, 8'hFF);
        chk(v2 == 8'hC0, "R5 coherent lsb", v2, 8'hC0);
        chk(v3 == 8'h00, "R4 beyond second byte", v3, 0);

        // R6: NACK after first byte releases SDA
        temp = 10'h000;
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h64, a1);
        bus_start();
        write_byte(abyte(1), a2);
        read_byte(v, 0);
        for (int i = 0; i < 9; i++) begin
            get_bit(x);
            chk(x == 1'b1, "R6 released", x, 1);
        end
        bus_stop();

        // R7: unknown commands and a write to the temperature command
        wr_reg(8'h5D, 8'h3C, a0, a1, a2);
        wr_reg(8'h61, 8'h33, a0, a1, a2);
        chk(a0 && !a1 && !a2, "R7 unknown nack", {a0, a1, a2}, 3'b100);
        wr_reg(8'h5E, 8'h44, a0, a1, a2);
        chk(!a1 && fsel == 8'h3C && tune == 8'h22 && ctl == 8'h00, "R7 regs kept", fsel, 8'h3C);
        bus_start();
        write_byte(abyte(1), a0);
        read_byte(v, 0);
        bus_stop();
        chk(v == 8'h3C, "R7 pointer kept", v, 8'h3C);
        wr_reg(8'h64, 8'h12, a0, a1, a2);
        chk(a1 && !a2 && fsel == 8'h3C && tune == 8'h22, "R7 temp write nack", a2, 0);

        // R9: repeated START after command, then mid-byte
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h5D, a1);
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h66, a1);
        write_byte(8'h77, a2);
        bus_stop();
        chk(tune == 8'h77 && fsel == 8'h3C, "R9 restart after cmd", tune, 8'h77);
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h5D, a1);
        put_bit(0); put_bit(0); put_bit(0);
        bus_start();
        write_byte(abyte(0), a0);
        write_byte(8'h60, a1);
        write_byte(8'h05, a2);
        bus_stop();
        chk(ctl == 8'h05 && fsel == 8'h3C, "R9 restart mid byte", ctl, 8'h05);
        // R9: STOP in the middle of a command byte
        bus_start();
        write_byte(abyte(0), a0);
        put_bit(0); put_bit(1); put_bit(1); put_bit(0);
        bus_stop();
        wr_reg(8'h66, 8'h44, a0, a1, a2);
        chk(a0 && a1 && a2 && tune == 8'h44, "R9 stop mid byte", tune, 8'h44);

        // R10: pull-down never rose with SCL high
        chk(viol == 0, "R10 pull timing", viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule